// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is a four-stage twisted-ring counter with eight working states. It is a shift register. On each clock every stage passes its bit to the next stage toward the last one. The first stage takes the inverted value of the last stage. The stage outputs form a sequence of eight codes in which only one bit changes per step. Downstream logic can therefore decode phases or gate timing windows from these outputs without glitches.

A plain twisted ring with 2^4 = 16 codes has eight codes that are not in the main loop. Plain complement feedback would run among those codes forever. Here a small detector looks at two bits only: the first stage and the last stage. When both are 0, the next clock loads the fixed code that has only the first stage set, in place of the normal shift. In the main loop only the all-zero code has that pattern, and 0001 is its correct successor anyway, so the detector does not disturb the main loop. It does catch every stray code within a few clocks.

The output bit i is stage Qi. Bit 0 is the first stage, and bit 3 is the last stage, which is fed back.

Top module: `jc_self_fix_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count_q` becomes 4'b0000 after that edge, whatever code it held before.
- R2: When no correction load happens, the next value of bit 0 is the inverse of the present bit 3.
- R3: When no correction load happens, each bit i (i = 1..3) takes the present value of bit i-1 at the rising edge.
- R4: When bit 0 and bit 3 are both 0, the next rising edge loads 4'b0001, meaning only bit 0 is set.
- R5: After reset, `count_q` (written as bits 3..0) steps through 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 and repeats with a period of eight clocks.
- R6: Once `count_q` holds one of the eight codes of R5, it never leaves that set of codes.
- R7: Each of the eight codes outside R5 moves, without reset, into the set of R5 codes within three clocks. The codes 0010, 0100 and 0110 need one clock. The codes 1001, 1010 and 1011 need two clocks. The codes 0101 and 1101 need three clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| count_q | output | 4 | Stage outputs, bit i is stage Qi |

## Verification
Every result of this block is due one rising edge after its cause. This holds for the reset clear, the shift, the inverted feedback and the correction load. The bench sets up a start code, then waits for exactly one rising edge and reads `count_q` at the following falling edge, half a period later. Then it compares the value with the table entry for that start code. The recovery bound of R7 is checked by stepping one edge at a time and reading at each falling edge. The bench counts the edges up to the first code in the R5 set and checks that count against three.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int unsigned JC_WIDTH = 4;

    // next-state selection for the ring
    typedef enum logic [1:0] {
        JC_OP_SHIFT = 2'd0,
        JC_OP_FIX   = 2'd1
    } jc_op_e;

endpackage

// File: rtl/jc_fix_detect.sv
module jc_fix_detect #(
    parameter int unsigned W = jc_pkg::JC_WIDTH
) (
    input  logic [W-1:0]   state_i,
    output jc_pkg::jc_op_e op_o
);
    import jc_pkg::*;

    logic head_low;
    logic tail_low;

    assign head_low = ~state_i[0];
    assign tail_low = ~state_i[W-1];

    always_comb begin
        if (head_low && tail_low) op_o = JC_OP_FIX;
        else                      op_o = JC_OP_SHIFT;
    end

endmodule

// File: rtl/jc_next_gen.sv
module jc_next_gen #(
    parameter int unsigned W = jc_pkg::JC_WIDTH
) (
    input  logic [W-1:0]   state_i,
    input  jc_pkg::jc_op_e op_i,
    output logic [W-1:0]   next_o
);
    import jc_pkg::*;

    always_comb begin
        if (op_i == JC_OP_FIX) next_o[0] = 1'b1;
        else                   next_o[0] = ~state_i[W-1];
    end

    for (genvar g = 1; g < W; g++) begin : g_stage
        always_comb begin
            if (op_i == JC_OP_FIX) next_o[g] = 1'b0;
            else                   next_o[g] = state_i[g-1];
        end
    end

endmodule

// File: rtl/jc_shift_reg.sv
module jc_shift_reg #(
    parameter int unsigned W = jc_pkg::JC_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= next_i;
    end

    assign state_o = state_q;

endmodule

// File: rtl/jc_self_fix_counter.sv
module jc_self_fix_counter #(
    parameter int unsigned W = jc_pkg::JC_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count_q
);
    import jc_pkg::*;

    jc_op_e       op;
    logic [W-1:0] next_word;

    jc_fix_detect #(.W(W)) u_detect (
        .state_i (count_q),
        .op_o    (op)
    );

    jc_next_gen #(.W(W)) u_next (
        .state_i (count_q),
        .op_i    (op),
        .next_o  (next_word)
    );

    jc_shift_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .next_i  (next_word),
        .state_o (count_q)
    );

    // a main-loop code has at most one place where neighbouring bits differ
    function automatic logic in_loop(input logic [W-1:0] w);
        int unsigned edges;
        edges = 0;
        for (int unsigned i = 1; i < W; i++) begin
            if (w[i] != w[i-1]) edges++;
        end
        return (edges <= 1);
    endfunction

    // R4
    fix_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !count_q[0] && !count_q[W-1]) |-> (count_q == W'(1)));

    // R3
    shift_path_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op == JC_OP_SHIFT) |-> (count_q[W-1:1] == $past(count_q[W-2:0])));

    // R2
    invert_feed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op == JC_OP_SHIFT) |-> (count_q[0] == !$past(count_q[W-1])));

    // R6
    loop_closed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_loop(count_q)) |-> in_loop(count_q));

endmodule

// File: tb/jc_self_fix_counter_tb_top.sv
`timescale 1ns/1ps
module jc_self_fix_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] count_q;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    jc_self_fix_counter dut_i (
        .clk     (clk),
        .rst     (rst),
        .count_q (count_q)
    );

    // {start, expected next}, written as bits 3..0
    localparam logic [7:0] STEP_TBL [16] = '{
        8'b0000_0001, 8'b0001_0011, 8'b0010_0001, 8'b0011_0111,
        8'b0100_0001, 8'b0101_1011, 8'b0110_0001, 8'b0111_1111,
        8'b1000_0000, 8'b1001_0010, 8'b1010_0100, 8'b1011_0110,
        8'b1100_1000, 8'b1101_1010, 8'b1110_1100, 8'b1111_1110
    };

    localparam logic [3:0] LOOP_TBL [8] = '{
        4'b0001, 4'b0011, 4'b0111, 4'b1111,
        4'b1110, 4'b1100, 4'b1000, 4'b0000
    };

    // {start code, clocks to reach the loop}
    localparam logic [7:0] REC_TBL [8] = '{
        8'b0010_0001, 8'b0100_0001, 8'b0110_0001, 8'b1001_0010,
        8'b1010_0010, 8'b1011_0010, 8'b0101_0011, 8'b1101_0011
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic is_loop(input logic [3:0] w);
        for (int i = 0; i < 8; i++) if (LOOP_TBL[i] == w) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // place a start code while reset is held, then let go of both
    task automatic inject(input logic [3:0] v);
        @(negedge clk);
        rst = 1'b1;
        force dut_i.u_reg.state_q = v;
        @(posedge clk);
        @(negedge clk);
        release dut_i.u_reg.state_q;
        rst = 1'b0;
        #0.1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step();
        step();
        check("R1 reset clear", count_q, 4'b0000);

        // table walk: one edge from each start code
        for (int i = 0; i < 16; i++) begin
            logic [3:0] st;
            logic [3:0] nx;
            st = STEP_TBL[i][7:4];
            nx = STEP_TBL[i][3:0];
            inject(st);
            step();
            if (!st[0] && !st[3]) check("R4 fix load", count_q, nx);
            else begin
                check("R3 shift", {count_q[3:1], 1'b0}, {nx[3:1], 1'b0});
                check("R2 inverted feed", {3'b000, count_q[0]}, {3'b000, nx[0]});
            end
        end

        // R5 order over two periods from reset
        @(negedge clk);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset again", count_q, 4'b0000);
        for (int k = 0; k < 16; k++) begin
            step();
            check("R5 loop order", count_q, LOOP_TBL[k % 8]);
        end

        // R6 closure from each loop code for eight clocks
        for (int i = 0; i < 8; i++) begin
            inject(LOOP_TBL[i]);
            for (int k = 0; k < 8; k++) begin
                step();
                check("R6 stays in loop", {3'b000, is_loop(count_q)}, 4'b0001);
            end
        end

        // R7 recovery bound per stray code
        for (int i = 0; i < 8; i++) begin
            int n;
            inject(REC_TBL[i][7:4]);
            n = 0;
            while (!is_loop(count_q) && n < 6) begin
                step();
                n++;
            end
            check("R7 recovery clocks", 4'(n), REC_TBL[i][3:0]);
        end

        // R1 reset overrides a stray code that would otherwise shift
        inject(4'b1101);
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R1 reset from stray", count_q, 4'b0000);
        rst = 1'b0;
        step();
        check("R5 first step after reset", count_q, 4'b0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule